// File: doc/BRIEF.md
# Ultra DMA Burst Host Controller

This block runs the host end of an ATA Ultra DMA burst, in both directions. It operates on the fast timing clock. When a burst is active, three bus lines take on new meanings. The DIOW_ line becomes STOP. The DIOR_ line becomes the host ready flag (data-in) or the host strobe (data-out). IORDY becomes the device ready flag (data-out) or the device strobe (data-in). When the burst ends, all three lines return to their plain register-transfer levels.

For data-out, the block takes words from a transmit stream and sends one word on every transition of its strobe. Strobe transitions are spaced by a parameter number of clock cycles. They stop when the device withdraws its ready flag. For data-in, the block captures one word on every transition of the device strobe and passes it to a receive stream. It withdraws its own ready flag early enough that the receive buffer can still take the words that arrive after the pause.

Either side can end a burst. At the end, the block drives a CRC-16 over the moved words onto the data bus while it releases the acknowledge.

The controller has eight states:
- IDLE: waits for `start_i`. Moves to WAIT_RQ.
- WAIT_RQ: waits for the device request. Moves to ACK.
- ACK: asserts the acknowledge, negates STOP and resets the strobe engine and the CRC. Moves to XFER after one cycle.
- XFER: moves data. Goes to RESTORE when the request drops (device ends the burst). Goes to HSTOP on `stop_req_i` (host ends the burst).
- HSTOP: asserts STOP and waits for the request to drop. Moves to RESTORE.
- RESTORE: returns the host strobe to high. Moves to CRC after one cycle.
- CRC: drives the CRC with the acknowledge still asserted. Moves to RELEASE after one cycle.
- RELEASE: negates the acknowledge and keeps driving the CRC. Moves to IDLE after one cycle.

Top module: `udma_host_burst`

## Requirements
- R1: After reset, and in IDLE and WAIT_RQ, `dmack_n_o`, `diow_stop_o` and `dior_o` are all 1 and `dd_oe_o` is 0.
- R2: `dmack_n_o` goes low only after `dmarq_i` has been high. In the first cycle it is low, `diow_stop_o` is 0 (STOP negated).
- R3: In a data-out burst, the host strobe on `dior_o` starts at 1. It makes no transition while `iordy_i` is 1 (device not ready).
- R4: In data-out, each transition of `dior_o`, either rising or falling, carries the next transmit word on `dd_o`, in stream order. Successive transitions are at least STROBE_CYC cycles apart.
- R5: After `iordy_i` rises during a data-out burst, at most two more strobe transitions occur. Transfer resumes once `iordy_i` is low again.
- R6: In a data-in burst, every change of `iordy_i` captures `dd_i`. The word appears on `rx_data_o` with `rx_valid_o` high one cycle later.
- R7: During a data-in transfer, `dior_o` (host ready, active low) is 1 in the cycle after `rx_free_i <= RX_SLACK`, and 0 in the cycle after `rx_free_i > RX_SLACK`.
- R8: On `stop_req_i`, `diow_stop_o` goes to 1 and `dmack_n_o` stays low until `dmarq_i` is low. In data-in, `dior_o` goes to 1, and words the device still strobes are captured.
- R9: If `dmarq_i` falls during transfer, the block stops strobing and proceeds to termination without `stop_req_i`.
- R10: `dior_o` is 1 in the cycle before `dmack_n_o` rises.
- R11: The CRC uses polynomial x^16+x^12+x^5+1 (0x1021) with seed 0x4ABA. Each word is fed MSB first. The CRC is reset at burst start and updated by every moved word. `dd_o` equals it with `dd_oe_o` high in the cycle `dmack_n_o` rises.
- R12: One cycle after `dmack_n_o` rises, all lines are back at register levels (as in R1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a burst (sampled in IDLE) |
| dir_out_i | input | 1 | 1 = data-out burst, 0 = data-in burst |
| stop_req_i | input | 1 | Host request to end the current burst |
| tx_data_i | input | 16 | Transmit stream word |
| tx_valid_i | input | 1 | Transmit word available |
| tx_ready_o | output | 1 | Transmit word taken this cycle |
| rx_data_o | output | 16 | Captured receive word |
| rx_valid_o | output | 1 | Receive word valid |
| rx_free_i | input | RX_FREE_W | Free entries in the receive buffer |
| dmarq_i | input | 1 | Device DMA request |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| diow_stop_o | output | 1 | DIOW_ line; STOP when high in a burst |
| dior_o | output | 1 | DIOR_ line; host ready (active low) or host strobe |
| iordy_i | input | 1 | IORDY line; device ready (active low) or device strobe |
| dd_i | input | 16 | Data bus in |
| dd_o | output | 16 | Data bus out |
| dd_oe_o | output | 1 | Data bus output enable |

## Verification
The bench builds the block with STROBE_CYC = 3 and RX_SLACK = 2. The short strobe spacing allows bursts of five and six words, a mid-burst pause and a resume within a few hundred cycles. The RX_SLACK value puts the ready threshold right at the two-free-entry boundary, so one step of `rx_free_i` between 2 and 3 flips the host ready flag. Odd and even word counts make the host strobe end low and high, which covers the restore step in both cases.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RQ,
        ST_ACK,
        ST_XFER,
        ST_HSTOP,
        ST_RESTORE,
        ST_CRC,
        ST_RELEASE
    } burst_st_e;

    // One word into the CRC, most significant bit first.
    function automatic logic [DATA_W-1:0] crc_step(
        input logic [DATA_W-1:0] crc_in,
        input logic [DATA_W-1:0] word,
        input logic [DATA_W-1:0] poly
    );
        logic [DATA_W-1:0] c;
        logic              fb;
        c = crc_in;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb = c[DATA_W-1] ^ word[b];
            c  = {c[DATA_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/udma_crc_acc.sv
module udma_crc_acc
    import udma_pkg::*;
#(
    parameter logic [DATA_W-1:0] POLY = 16'h1021,
    parameter logic [DATA_W-1:0] SEED = 16'h4ABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] crc_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_o <= SEED;
        end else if (clear_i) begin
            crc_o <= SEED;
        end else if (en_i) begin
            crc_o <= crc_step(crc_o, word_i, POLY);
        end
    end

endmodule

// File: rtl/udma_out_strobe.sv
module udma_out_strobe
    import udma_pkg::*;
#(
    parameter int STROBE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_i,
    input  logic              run_i,
    input  logic              restore_i,
    input  logic              ddmardy_n_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [DATA_W-1:0] word_o,
    output logic              hstrobe_o,
    output logic              fire_o
);

    localparam int CNT_W = $clog2(STROBE_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STROBE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             loaded_q;
    logic             rdy_n_q;

    assign tx_ready_o = run_i && !loaded_q && tx_valid_i;
    assign fire_o     = run_i && loaded_q && (cnt_q == '0) && !rdy_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            loaded_q  <= 1'b0;
            rdy_n_q   <= 1'b1;
            hstrobe_o <= 1'b1;
            word_o    <= '0;
        end else begin
            rdy_n_q <= ddmardy_n_i;
            if (begin_i) begin
                hstrobe_o <= 1'b1;
                loaded_q  <= 1'b0;
                cnt_q     <= RELOAD;
            end else begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                if (fire_o) begin
                    hstrobe_o <= ~hstrobe_o;
                    loaded_q  <= 1'b0;
                    cnt_q     <= RELOAD;
                end else if (restore_i && !hstrobe_o) begin
                    hstrobe_o <= 1'b1;
                end
                if (tx_ready_o) begin
                    loaded_q <= 1'b1;
                    word_o   <= tx_data_i;
                end
            end
        end
    end

endmodule

// File: rtl/udma_in_capture.sv
module udma_in_capture
    import udma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              dstrobe_i,
    input  logic [DATA_W-1:0] dd_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o
);

    logic ds_q;
    logic toggled;

    assign toggled = dstrobe_i != ds_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q    <= 1'b1;
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            ds_q    <= dstrobe_i;
            valid_o <= arm_i && toggled;
            if (arm_i && toggled) word_o <= dd_i;
        end
    end

endmodule

// File: rtl/udma_host_burst.sv
module udma_host_burst
    import udma_pkg::*;
#(
    parameter int                STROBE_CYC = 4,
    parameter int                RX_SLACK   = 2,
    parameter int                RX_FREE_W  = 6,
    parameter logic [DATA_W-1:0] CRC_POLY   = 16'h1021,
    parameter logic [DATA_W-1:0] CRC_SEED   = 16'h4ABA
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 dir_out_i,
    input  logic                 stop_req_i,
    input  logic [DATA_W-1:0]    tx_data_i,
    input  logic                 tx_valid_i,
    output logic                 tx_ready_o,
    output logic [DATA_W-1:0]    rx_data_o,
    output logic                 rx_valid_o,
    input  logic [RX_FREE_W-1:0] rx_free_i,
    input  logic                 dmarq_i,
    output logic                 dmack_n_o,
    output logic                 diow_stop_o,
    output logic                 dior_o,
    input  logic                 iordy_i,
    input  logic [DATA_W-1:0]    dd_i,
    output logic [DATA_W-1:0]    dd_o,
    output logic                 dd_oe_o
);

    localparam logic [RX_FREE_W-1:0] SLACK_LIM = RX_FREE_W'(RX_SLACK);

    burst_st_e         state_q, state_d;
    logic              dir_out_q;
    logic              rdy_n_q;
    logic [DATA_W-1:0] out_word, in_word, crc_val, crc_word;
    logic              hstrobe, out_fire, in_valid;
    logic              out_begin, out_run, out_restore, in_arm;

    // State register and registered side information
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            dir_out_q <= 1'b0;
            rdy_n_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) dir_out_q <= dir_out_i;
            rdy_n_q <= (rx_free_i <= SLACK_LIM);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_WAIT_RQ;
            ST_WAIT_RQ: if (dmarq_i) state_d = ST_ACK;
            ST_ACK:     state_d = ST_XFER;
            ST_XFER: begin
                if (!dmarq_i)        state_d = ST_RESTORE;
                else if (stop_req_i) state_d = ST_HSTOP;
            end
            ST_HSTOP:   if (!dmarq_i) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_CRC;
            ST_CRC:     state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Bus line outputs
    always_comb begin
        dmack_n_o   = 1'b1;
        diow_stop_o = 1'b1;
        dior_o      = 1'b1;
        dd_oe_o     = 1'b0;
        dd_o        = out_word;
        unique case (state_q)
            ST_IDLE, ST_WAIT_RQ: begin
            end
            ST_ACK: begin
                dmack_n_o   = 1'b0;
                diow_stop_o = 1'b0;
                dior_o      = dir_out_q ? hstrobe : 1'b1;
                dd_oe_o     = dir_out_q;
            end
            ST_XFER: begin
                dmack_n_o   = 1'b0;
                diow_stop_o = 1'b0;
                dior_o      = dir_out_q ? hstrobe : rdy_n_q;
                dd_oe_o     = dir_out_q;
            end
            ST_HSTOP, ST_RESTORE: begin
                dmack_n_o = 1'b0;
                dior_o    = dir_out_q ? hstrobe : 1'b1;
                dd_oe_o   = dir_out_q;
            end
            ST_CRC: begin
                dmack_n_o = 1'b0;
                dior_o    = dir_out_q ? hstrobe : 1'b1;
                dd_oe_o   = 1'b1;
                dd_o      = crc_val;
            end
            ST_RELEASE: begin
                dd_oe_o = 1'b1;
                dd_o    = crc_val;
            end
            default: begin
            end
        endcase
    end

    assign out_begin   = state_q == ST_ACK;
    assign out_run     = (state_q == ST_XFER) && dir_out_q;
    assign out_restore = state_q == ST_RESTORE;
    assign in_arm      = !dir_out_q && (state_q == ST_XFER || state_q == ST_HSTOP);
    assign crc_word    = dir_out_q ? out_word : in_word;

    udma_out_strobe #(.STROBE_CYC(STROBE_CYC)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .begin_i    (out_begin),
        .run_i      (out_run),
        .restore_i  (out_restore),
        .ddmardy_n_i(iordy_i),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .word_o     (out_word),
        .hstrobe_o  (hstrobe),
        .fire_o     (out_fire)
    );

    udma_in_capture u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (in_arm),
        .dstrobe_i(iordy_i),
        .dd_i     (dd_i),
        .word_o   (in_word),
        .valid_o  (in_valid)
    );

    udma_crc_acc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(out_begin),
        .en_i   (out_fire | in_valid),
        .word_i (crc_word),
        .crc_o  (crc_val)
    );

    assign rx_data_o  = in_word;
    assign rx_valid_o = in_valid;

endmodule

// File: rtl/udma_host_burst_chk.sv
module udma_host_burst_chk #(
    parameter int STROBE_CYC = 4,
    parameter int RX_SLACK   = 2,
    parameter int RX_FREE_W  = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dir_out_q,
    input logic                 dmarq_i,
    input logic                 iordy_i,
    input logic [RX_FREE_W-1:0] rx_free_i,
    input logic                 dmack_n_o,
    input logic                 diow_stop_o,
    input logic                 dior_o,
    input logic                 dd_oe_o
);

    localparam int GW = $clog2(STROBE_CYC + 1) + 1;
    localparam logic [GW-1:0] GAP_MIN = GW'(STROBE_CYC);

    logic          prev_dior;
    logic [GW-1:0] gap_q;
    logic [2:0]    pause_edges;
    logic          out_edge;
    logic          xfer_line;

    assign xfer_line = !dmack_n_o && !diow_stop_o;
    assign out_edge  = dir_out_q && xfer_line && (dior_o != prev_dior);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_dior   <= 1'b1;
            gap_q       <= GAP_MIN;
            pause_edges <= '0;
        end else begin
            prev_dior <= dior_o;
            if (dmack_n_o)                gap_q <= GAP_MIN;
            else if (out_edge)            gap_q <= GW'(1);
            else if (gap_q < GAP_MIN)     gap_q <= gap_q + 1'b1;
            if (!(iordy_i && dir_out_q && !dmack_n_o)) pause_edges <= '0;
            else if (out_edge && pause_edges != 3'd7)  pause_edges <= pause_edges + 1'b1;
        end
    end

    AST_ACK_AFTER_RQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n_o) |-> $past(dmarq_i)); // R2
    AST_ACK_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n_o) |-> !diow_stop_o); // R2
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_edge |-> gap_q >= GAP_MIN); // R4
    AST_PAUSE_SLACK: assert property (@(posedge clk) disable iff (!rst_n)
        pause_edges <= 3'd2); // R5
    AST_RX_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out_q && xfer_line && $past(xfer_line))
            |-> dior_o == $past(rx_free_i <= RX_FREE_W'(RX_SLACK))); // R7
    AST_RELEASE_RQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n_o) |-> !dmarq_i); // R8
    AST_STROBE_HIGH_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n_o) |-> $past(dior_o)); // R10
    AST_CRC_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n_o) |-> dd_oe_o); // R11
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (dmack_n_o && $past(dmack_n_o)) |-> (!dd_oe_o && diow_stop_o && dior_o)); // R12

endmodule

bind udma_host_burst udma_host_burst_chk #(
    .STROBE_CYC(STROBE_CYC),
    .RX_SLACK  (RX_SLACK),
    .RX_FREE_W (RX_FREE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_out_q  (dir_out_q),
    .dmarq_i    (dmarq_i),
    .iordy_i    (iordy_i),
    .rx_free_i  (rx_free_i),
    .dmack_n_o  (dmack_n_o),
    .diow_stop_o(diow_stop_o),
    .dior_o     (dior_o),
    .dd_oe_o    (dd_oe_o)
);

// File: tb/udma_host_burst_tb.sv
module udma_host_burst_tb;

    localparam int SC = 3;
    localparam int FW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, dir_out_i = 1'b0, stop_req_i = 1'b0;
    logic [15:0]   tx_data_i;
    logic          tx_valid_i, tx_ready_o;
    logic [15:0]   rx_data_o;
    logic          rx_valid_o;
    logic [FW-1:0] rx_free_i = 6'd8;
    logic          dmarq_i = 1'b0, dmack_n_o, diow_stop_o, dior_o;
    logic          iordy_i = 1'b1;
    logic [15:0]   dd_i = 16'h0, dd_o;
    logic          dd_oe_o;

    int n_chk = 0, n_err = 0;

    // monitor-owned state
    logic [15:0] tx_mem [0:63];
    int          tx_idx = 0, tx_n = 0;
    bit          pop_pend = 0;
    int          cyc = 0;
    logic [15:0] out_mem [0:63];
    int          out_cyc [0:63];
    int          out_cnt = 0;
    logic [15:0] in_mem [0:63];
    int          in_cnt = 0;
    int          rel_cnt = 0;
    logic [15:0] rel_dd;
    logic        rel_oe, rel_dior;
    logic        prev_dior = 1'b1, prev_dmack = 1'b1;

    assign tx_valid_i = tx_idx < tx_n;
    assign tx_data_i  = tx_mem[tx_idx[5:0]];

    always #2 clk = ~clk;

    udma_host_burst #(
        .STROBE_CYC(SC),
        .RX_SLACK  (2),
        .RX_FREE_W (FW)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dir_out_i  (dir_out_i),
        .stop_req_i (stop_req_i),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .rx_free_i  (rx_free_i),
        .dmarq_i    (dmarq_i),
        .dmack_n_o  (dmack_n_o),
        .diow_stop_o(diow_stop_o),
        .dior_o     (dior_o),
        .iordy_i    (iordy_i),
        .dd_i       (dd_i),
        .dd_o       (dd_o),
        .dd_oe_o    (dd_oe_o)
    );

    always @(negedge clk) begin
        cyc++;
        if (pop_pend && tx_idx < 63) tx_idx++;
        pop_pend = tx_ready_o;
        if (!dmack_n_o && !diow_stop_o && dir_out_i && dior_o != prev_dior && out_cnt < 64) begin
            out_mem[out_cnt] = dd_o;
            out_cyc[out_cnt] = cyc;
            out_cnt++;
        end
        if (rx_valid_o && in_cnt < 64) begin
            in_mem[in_cnt] = rx_data_o;
            in_cnt++;
        end
        if (dmack_n_o && !prev_dmack) begin
            rel_dd   = dd_o;
            rel_oe   = dd_oe_o;
            rel_dior = prev_dior;
            rel_cnt++;
        end
        prev_dior  = dior_o;
        prev_dmack = dmack_n_o;
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int b = 15; b >= 0; b--) begin
            fb = r[15] ^ d[b];
            r  = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic start_burst(input bit dir);
        int k;
        @(negedge clk);
        dir_out_i = dir;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        check(dmack_n_o == 1'b1, "R2 no ack before request", dmack_n_o, 1);
        dmarq_i = 1'b1;
        k = 0;
        while (dmack_n_o && k < 50) begin @(negedge clk); k++; end
        check(diow_stop_o == 1'b0, "R2 stop negated at ack", diow_stop_o, 0);
    endtask

    task automatic finish_burst(input logic [15:0] exp_crc);
        int base, k;
        base = rel_cnt;
        k = 0;
        while (rel_cnt == base && k < 100) begin @(negedge clk); k++; end
        check(rel_cnt > base, "R8 acknowledge released", rel_cnt - base, 1);
        check(rel_dd == exp_crc && rel_oe, "R11 crc on bus at release", rel_dd, exp_crc);
        check(rel_dior == 1'b1, "R10 strobe high before release", rel_dior, 1);
        @(negedge clk);
        check(dmack_n_o && diow_stop_o && dior_o && !dd_oe_o, "R12 register levels",
              {dmack_n_o, diow_stop_o, dior_o, dd_oe_o}, 4'b1110);
    endtask

    task automatic out_burst(input int n, input int pause_at, input bit host_term);
        int ob, c0, c1, k;
        logic [15:0] crc;
        bit ok_words, ok_gap;
        for (int i = 0; i < n; i++) tx_mem[(tx_idx + i) % 64] = 16'h3C00 + 16'(i * 37 + n);
        tx_n = tx_idx + n;
        ob = out_cnt;
        iordy_i = 1'b1;
        start_burst(1'b1);
        repeat (12) @(negedge clk);
        check(out_cnt == ob && dior_o == 1'b1, "R3 no strobe while device not ready", out_cnt - ob, 0);
        iordy_i = 1'b0;
        if (pause_at > 0) begin
            k = 0;
            while (out_cnt - ob < pause_at && k < 200) begin @(negedge clk); k++; end
            iordy_i = 1'b1;
            c0 = out_cnt;
            repeat (20) @(negedge clk);
            check(out_cnt - c0 <= 2, "R5 at most two edges after pause", out_cnt - c0, 2);
            c1 = out_cnt;
            repeat (10) @(negedge clk);
            check(out_cnt == c1, "R5 strobe held during pause", out_cnt - c1, 0);
            iordy_i = 1'b0;
        end
        k = 0;
        while (out_cnt - ob < n && k < 300) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
        check(out_cnt - ob == n, "R4 edge count", out_cnt - ob, n);
        ok_words = 1; ok_gap = 1;
        crc = 16'h4ABA;
        for (int i = 0; i < n; i++) begin
            if (out_mem[ob + i] != 16'h3C00 + 16'(i * 37 + n)) ok_words = 0;
            if (i > 0 && out_cyc[ob + i] - out_cyc[ob + i - 1] < SC) ok_gap = 0;
            crc = ref_crc(crc, out_mem[ob + i]);
        end
        check(ok_words, "R4 words in order per edge", ok_words, 1);
        check(ok_gap, "R4 edge spacing", ok_gap, 1);
        if (host_term) begin
            stop_req_i = 1'b1;
            @(negedge clk);
            stop_req_i = 1'b0;
            repeat (5) @(negedge clk);
            check(diow_stop_o == 1'b1 && dmack_n_o == 1'b0, "R8 stop held until request drops",
                  {diow_stop_o, dmack_n_o}, 2'b10);
            dmarq_i = 1'b0;
        end else begin
            c0 = out_cnt;
            dmarq_i = 1'b0;
            repeat (2) @(negedge clk);
            check(diow_stop_o == 1'b1 && out_cnt == c0, "R9 device end stops strobing",
                  out_cnt - c0, 0);
        end
        finish_burst(crc);
    endtask

    task automatic in_word(input logic [15:0] w);
        @(negedge clk);
        dd_i    = w;
        iordy_i = ~iordy_i;
        repeat (3) @(negedge clk);
    endtask

    task automatic in_burst(input int n, input bit host_term);
        int ib, tot;
        logic [15:0] crc;
        bit ok_words;
        ib = in_cnt;
        iordy_i = 1'b1;
        rx_free_i = 6'd8;
        start_burst(1'b0);
        @(negedge clk);
        check(dior_o == 1'b0, "R7 host ready with room", dior_o, 0);
        for (int i = 0; i < n; i++) in_word(16'hB100 ^ 16'(i * 91 + n));
        rx_free_i = 6'd2;
        @(negedge clk);
        check(dior_o == 1'b1, "R7 not ready at two free", dior_o, 1);
        rx_free_i = 6'd3;
        @(negedge clk);
        check(dior_o == 1'b0, "R7 ready at three free", dior_o, 0);
        tot = n;
        if (host_term) begin
            stop_req_i = 1'b1;
            @(negedge clk);
            stop_req_i = 1'b0;
            @(negedge clk);
            check(diow_stop_o && dior_o && !dmack_n_o, "R8 stop and host not ready",
                  {diow_stop_o, dior_o, dmack_n_o}, 3'b110);
            for (int i = n; i < n + 2; i++) in_word(16'hB100 ^ 16'(i * 91 + n));
            tot = n + 2;
        end
        check(in_cnt - ib == tot, "R6 word count", in_cnt - ib, tot);
        ok_words = 1;
        crc = 16'h4ABA;
        for (int i = 0; i < tot; i++) begin
            if (in_mem[ib + i] != (16'hB100 ^ 16'(i * 91 + n))) ok_words = 0;
            crc = ref_crc(crc, in_mem[ib + i]);
        end
        check(ok_words, "R6 captured words on both strobe edges", ok_words, 1);
        dmarq_i = 1'b0;
        finish_burst(crc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dmack_n_o && diow_stop_o && dior_o && !dd_oe_o, "R1 reset levels",
              {dmack_n_o, diow_stop_o, dior_o, dd_oe_o}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dmack_n_o && diow_stop_o && dior_o && !dd_oe_o, "R1 idle levels",
              {dmack_n_o, diow_stop_o, dior_o, dd_oe_o}, 4'b1110);
        out_burst(6, 2, 1'b0);
        out_burst(5, 0, 1'b1);
        in_burst(4, 1'b0);
        in_burst(3, 1'b1);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule